// File: doc/BRIEF.md
# Boot Sector Guard and Erase Scope Unit

This unit sits inside a byte-wide flash controller model with an 18-bit address space. It turns each program or erase request into a verdict: whether the request may proceed, which of the five sectors an erase touches, and whether the request is a silent no-op. The space is split into five sectors of unequal size: a 16K boot sector, two 8K parameter sectors, and main sectors of 96K and 128K. A build-time parameter picks whether the boot sector sits at the bottom or at the top of the space.

A sticky lock bit protects the boot sector. Once it is set, the boot sector can be neither programmed nor erased unless a high-voltage override input is active. Removing the override brings the protection back at once. The lock is loaded from a parameter only by the power-on reset; the ordinary reset leaves it alone. While the controller is in identification mode, the lock can be read back at a fixed probe address inside the boot sector.

Top module: `bsp_guard`

## Requirements
- R1: With `TOP_BOOT=0` the sectors are: boot 0x00000-0x03FFF, first parameter 0x04000-0x05FFF, second parameter 0x06000-0x07FFF, first main 0x08000-0x1FFFF, second main 0x20000-0x3FFFF. Erase mask bit 0 is boot, bit 1 the first parameter, bit 2 the second parameter, bit 3 the first main and bit 4 the second main sector. A sector erase (`req_kind`=1) outside the boot sector and outside the first main sector grants and sets only that sector's bit.
- R2: With `TOP_BOOT=1` the sectors are: boot 0x3C000-0x3FFFF, first parameter 0x3A000-0x3BFFF, second parameter 0x38000-0x39FFF, first main 0x20000-0x37FFF, second main 0x00000-0x1FFFF. The mask bit order is the same as in R1.
- R3: A sector erase whose address falls in the first main sector grants with mask 0b01110, so both parameter sectors are cleared along with it.
- R4: A sector erase whose address falls in the boot sector raises `noop` for one cycle, with `grant` low and a zero mask, whatever the lock and override state.
- R5: A chip erase (`req_kind`=2) always grants. Its mask is 0b11111 when the boot sector is unprotected and 0b11110 when the lock is set and the override is low.
- R6: A byte program (`req_kind`=0) grants with a zero mask, except that a program into the boot sector while the lock is set and the override is low raises `reject` instead. At most one of `grant`, `reject` and `noop` is high at a time.
- R7: While `hv_override` is high, a set lock does not protect the boot sector. Boot programs grant and chip erase covers all five sectors. Protection returns in the first request after the override goes low.
- R8: `lock_set` sets `lock_state` at the next clock edge. Only `por` clears it, loading `LOCK_INIT` (default 0). `rst` leaves it unchanged.
- R9: When `id_mode` is high and `rd_addr` equals the boot sector base plus 0x0002, the next cycle shows `status_hit`=1 and `status_byte` = {7'b0, lock}. Any other address, or `id_mode` low, gives `status_hit`=0 and `status_byte`=0.
- R10: The verdict outputs are registered. They reflect a request sampled with `req_valid` one clock later and are all zero in every cycle that follows a clock with no request. Request kind 3 is reserved and gives an all-zero verdict.
- R11: After `rst` or `por`, every verdict and status output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the outputs; does not touch the lock |
| por | input | 1 | Synchronous power-on reset; clears the outputs and loads the lock from `LOCK_INIT` |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 0 byte program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | ADDR_W | Target byte address of the request |
| hv_override | input | 1 | High-voltage override level; lifts boot protection while high |
| lock_set | input | 1 | Strobe that sets the sticky boot lock |
| id_mode | input | 1 | Identification mode is active |
| rd_addr | input | ADDR_W | Read address used for the lock probe |
| grant | output | 1 | Request allowed |
| reject | output | 1 | Program refused because the boot sector is protected |
| noop | output | 1 | Boot-sector erase dropped without effect |
| erase_mask | output | 5 | Sectors to erase, bit order as in R1 |
| lock_state | output | 1 | Current boot lock bit |
| status_hit | output | 1 | Last read hit the lock probe in identification mode |
| status_byte | output | 8 | Lock probe byte, lock on bit 0 |

## Verification
The hardest situation to reach is the mix of a set lock with the override being raised and dropped, together with the ordinary reset, which must leave the lock intact. A power-on reset is the only way to clear the lock again. The stimulus drives a seeded random stream of requests whose addresses are biased onto the sector edges of both layouts. It sprinkles in lock strobes, override changes, ordinary resets and occasional power-on resets, so the lock is seen in both states many times. Two instances, one per layout, share the stimulus, and a bench model predicts each verdict, mask and probe byte.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int NSEC = 5;

    typedef enum logic [2:0] {
        SEC_BOOT  = 3'd0,
        SEC_PAR1  = 3'd1,
        SEC_PAR2  = 3'd2,
        SEC_MAIN1 = 3'd3,
        SEC_MAIN2 = 3'd4
    } sector_e;

    typedef enum logic [1:0] {
        REQ_PROG  = 2'd0,
        REQ_SECT  = 2'd1,
        REQ_CHIP  = 2'd2,
        REQ_RSVD  = 2'd3
    } req_kind_e;

    typedef logic [NSEC-1:0] sec_mask_t;

    typedef struct packed {
        logic      grant;
        logic      reject;
        logic      noop;
        sec_mask_t mask;
    } verdict_t;

    localparam sec_mask_t MASK_ALL = '1;

    function automatic sec_mask_t sec_bit(input sector_e s);
        sec_mask_t m;
        m = '0;
        m[s] = 1'b1;
        return m;
    endfunction

    // erase of the first main sector drags both parameter sectors along
    function automatic sec_mask_t main1_bundle();
        return sec_bit(SEC_PAR1) | sec_bit(SEC_PAR2) | sec_bit(SEC_MAIN1);
    endfunction

    function automatic sec_mask_t chip_scope(input logic boot_guarded);
        return boot_guarded ? (MASK_ALL & ~sec_bit(SEC_BOOT)) : MASK_ALL;
    endfunction

endpackage

// File: rtl/bsp_sector_map.sv
module bsp_sector_map
    import bsp_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output sector_e           sector
);
    localparam int unsigned SPACE   = 32'd1 << ADDR_W;
    localparam int unsigned BOOT_SZ = SPACE / 16;
    localparam int unsigned PAR_SZ  = SPACE / 32;
    localparam int unsigned HALF    = SPACE / 2;

    logic [31:0] a32;
    assign a32 = 32'(addr);

    generate
        if (TOP_BOOT) begin : g_top
            localparam int unsigned BOOT_LO = SPACE - BOOT_SZ;
            localparam int unsigned P1_LO   = BOOT_LO - PAR_SZ;
            localparam int unsigned P2_LO   = P1_LO - PAR_SZ;
            always_comb begin
                if (a32 >= BOOT_LO)      sector = SEC_BOOT;
                else if (a32 >= P1_LO)   sector = SEC_PAR1;
                else if (a32 >= P2_LO)   sector = SEC_PAR2;
                else if (a32 >= HALF)    sector = SEC_MAIN1;
                else                     sector = SEC_MAIN2;
            end
        end else begin : g_bottom
            localparam int unsigned P1_LO = BOOT_SZ;
            localparam int unsigned P2_LO = P1_LO + PAR_SZ;
            localparam int unsigned M1_LO = P2_LO + PAR_SZ;
            always_comb begin
                if (a32 < P1_LO)         sector = SEC_BOOT;
                else if (a32 < P2_LO)    sector = SEC_PAR1;
                else if (a32 < M1_LO)    sector = SEC_PAR2;
                else if (a32 < HALF)     sector = SEC_MAIN1;
                else                     sector = SEC_MAIN2;
            end
        end
    endgenerate

endmodule

// File: rtl/bsp_lock_reg.sv
module bsp_lock_reg #(
    parameter bit LOCK_INIT = 1'b0
) (
    input  logic clk,
    input  logic por,
    input  logic set_strobe,
    output logic locked
);
    // Sticky: only the power-on reset brings it back to the initial value.
    always_ff @(posedge clk) begin
        if (por)
            locked <= LOCK_INIT;
        else if (set_strobe)
            locked <= 1'b1;
    end

endmodule

// File: rtl/bsp_scope_eval.sv
module bsp_scope_eval
    import bsp_pkg::*;
(
    input  logic [1:0] kind,
    input  sector_e    sector,
    input  logic       locked,
    input  logic       hv_override,
    output verdict_t   verdict
);
    logic      guarded;
    req_kind_e k;

    assign guarded = locked & ~hv_override;
    assign k       = req_kind_e'(kind);

    always_comb begin
        verdict = '0;
        unique case (k)
            REQ_PROG: begin
                if (sector == SEC_BOOT && guarded)
                    verdict.reject = 1'b1;
                else
                    verdict.grant = 1'b1;
            end
            REQ_SECT: begin
                if (sector == SEC_BOOT) begin
                    verdict.noop = 1'b1;
                end else if (sector == SEC_MAIN1) begin
                    verdict.grant = 1'b1;
                    verdict.mask  = main1_bundle();
                end else begin
                    verdict.grant = 1'b1;
                    verdict.mask  = sec_bit(sector);
                end
            end
            REQ_CHIP: begin
                verdict.grant = 1'b1;
                verdict.mask  = chip_scope(guarded);
            end
            default: verdict = '0;
        endcase
    end

endmodule

// File: rtl/bsp_id_status.sv
module bsp_id_status #(
    parameter int ADDR_W   = 18,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              locked,
    output logic              hit,
    output logic [7:0]        data
);
    localparam int unsigned SPACE   = 32'd1 << ADDR_W;
    localparam int unsigned BOOT_SZ = SPACE / 16;
    localparam int unsigned BASE    = TOP_BOOT ? (SPACE - BOOT_SZ) : 32'd0;
    localparam logic [ADDR_W-1:0] PROBE = ADDR_W'(BASE + 32'd2);

    logic probe_now;
    assign probe_now = id_mode && (rd_addr == PROBE);

    always_ff @(posedge clk) begin
        if (clr) begin
            hit  <= 1'b0;
            data <= 8'h00;
        end else begin
            hit  <= probe_now;
            data <= probe_now ? {7'b0, locked} : 8'h00;
        end
    end

endmodule

// File: rtl/bsp_guard.sv
module bsp_guard
    import bsp_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter bit TOP_BOOT  = 1'b0,
    parameter bit LOCK_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              hv_override,
    input  logic              lock_set,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              grant,
    output logic              reject,
    output logic              noop,
    output logic [4:0]        erase_mask,
    output logic              lock_state,
    output logic              status_hit,
    output logic [7:0]        status_byte
);
    sector_e  req_sector;
    verdict_t verdict_d;
    verdict_t verdict_q;
    logic     locked;
    logic     clr_out;

    assign clr_out = rst | por;

    bsp_sector_map #(
        .ADDR_W   (ADDR_W),
        .TOP_BOOT (TOP_BOOT)
    ) u_map (
        .addr   (req_addr),
        .sector (req_sector)
    );

    bsp_lock_reg #(
        .LOCK_INIT (LOCK_INIT)
    ) u_lock (
        .clk        (clk),
        .por        (por),
        .set_strobe (lock_set),
        .locked     (locked)
    );

    bsp_scope_eval u_eval (
        .kind        (req_kind),
        .sector      (req_sector),
        .locked      (locked),
        .hv_override (hv_override),
        .verdict     (verdict_d)
    );

    bsp_id_status #(
        .ADDR_W   (ADDR_W),
        .TOP_BOOT (TOP_BOOT)
    ) u_status (
        .clk     (clk),
        .clr     (clr_out),
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .locked  (locked),
        .hit     (status_hit),
        .data    (status_byte)
    );

    always_ff @(posedge clk) begin
        if (clr_out)
            verdict_q <= '0;
        else if (req_valid)
            verdict_q <= verdict_d;
        else
            verdict_q <= '0;
    end

    assign grant      = verdict_q.grant;
    assign reject     = verdict_q.reject;
    assign noop       = verdict_q.noop;
    assign erase_mask = verdict_q.mask;
    assign lock_state = locked;

endmodule

// File: rtl/bsp_guard_chk.sv
module bsp_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       por,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       lock_set,
    input logic       grant,
    input logic       reject,
    input logic       noop,
    input logic [4:0] erase_mask,
    input logic       lock_state,
    input logic [7:0] status_byte
);
    assert_one_verdict_R6: assert property (@(posedge clk) disable iff (rst || por)
        $onehot0({grant, reject, noop}));

    assert_reject_no_mask_R6: assert property (@(posedge clk) disable iff (rst || por)
        reject |-> (erase_mask == 5'b0));

    assert_noop_quiet_R4: assert property (@(posedge clk) disable iff (rst || por)
        noop |-> (erase_mask == 5'b0 && !grant));

    assert_chip_scope_R5: assert property (@(posedge clk) disable iff (rst || por)
        (req_valid && req_kind == 2'd2) |=> (grant && erase_mask[4:1] == 4'hF));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst || por)
        !req_valid |=> (!grant && !reject && !noop && erase_mask == 5'b0));

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (por)
        lock_state |=> lock_state);

    assert_lock_set_R8: assert property (@(posedge clk) disable iff (por)
        lock_set |=> lock_state);

    assert_status_upper_R9: assert property (@(posedge clk) disable iff (rst || por)
        status_byte[7:1] == 7'b0);

endmodule

bind bsp_guard bsp_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .por         (por),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .lock_set    (lock_set),
    .grant       (grant),
    .reject      (reject),
    .noop        (noop),
    .erase_mask  (erase_mask),
    .lock_state  (lock_state),
    .status_byte (status_byte)
);

// File: tb/bsp_guard_tb.sv
`timescale 1ns/1ps
module bsp_guard_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [17:0] req_addr = '0;
    logic        hv_override = 1'b0;
    logic        lock_set = 1'b0;
    logic        id_mode = 1'b0;
    logic [17:0] rd_addr = '0;

    logic        g_b, r_b, n_b, l_b, h_b;
    logic [4:0]  m_b;
    logic [7:0]  s_b;
    logic        g_t, r_t, n_t, l_t, h_t;
    logic [4:0]  m_t;
    logic [7:0]  s_t;

    int total = 0;
    int bad   = 0;
    bit mdl_lock = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bsp_guard #(.ADDR_W(18), .TOP_BOOT(1'b0), .LOCK_INIT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .por(por), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .hv_override(hv_override), .lock_set(lock_set),
        .id_mode(id_mode), .rd_addr(rd_addr), .grant(g_b), .reject(r_b), .noop(n_b),
        .erase_mask(m_b), .lock_state(l_b), .status_hit(h_b), .status_byte(s_b));

    bsp_guard #(.ADDR_W(18), .TOP_BOOT(1'b1), .LOCK_INIT(1'b0)) u_dut_top (
        .clk(clk), .rst(rst), .por(por), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .hv_override(hv_override), .lock_set(lock_set),
        .id_mode(id_mode), .rd_addr(rd_addr), .grant(g_t), .reject(r_t), .noop(n_t),
        .erase_mask(m_t), .lock_state(l_t), .status_hit(h_t), .status_byte(s_t));

    // sector index per the maps in R1 and R2
    function automatic int ref_sector(input logic [17:0] a, input bit top);
        if (!top) begin
            if (a < 18'h04000) return 0;
            if (a < 18'h06000) return 1;
            if (a < 18'h08000) return 2;
            if (a < 18'h20000) return 3;
            return 4;
        end
        if (a >= 18'h3C000) return 0;
        if (a >= 18'h3A000) return 1;
        if (a >= 18'h38000) return 2;
        if (a >= 18'h20000) return 3;
        return 4;
    endfunction

    // {grant, reject, noop, mask[4:0]}
    function automatic logic [7:0] ref_verdict(input logic [1:0] k, input logic [17:0] a,
                                               input bit top, input bit lk, input bit hv);
        int  s;
        bit  guarded;
        s = ref_sector(a, top);
        guarded = lk && !hv;
        case (k)
            2'd0: return (s == 0 && guarded) ? 8'b010_00000 : 8'b100_00000;
            2'd1: begin
                if (s == 0) return 8'b001_00000;
                if (s == 3) return 8'b100_01110;
                return {3'b100, 5'(1 << s)};
            end
            2'd2: return guarded ? 8'b100_11110 : 8'b100_11111;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [8:0] ref_status(input bit im, input logic [17:0] a,
                                              input bit top, input bit lk);
        logic [17:0] probe;
        probe = top ? 18'h3C002 : 18'h00002;
        if (im && a == probe) return {1'b1, 7'b0, lk};
        return 9'h000;
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] got,
                         input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic check_both(input string req, input logic [1:0] k, input logic [17:0] a,
                              input bit hv);
        check(req, "bottom verdict", 16'({g_b, r_b, n_b, m_b}),
              16'(ref_verdict(k, a, 1'b0, mdl_lock, hv)));
        check(req, "top verdict", 16'({g_t, r_t, n_t, m_t}),
              16'(ref_verdict(k, a, 1'b1, mdl_lock, hv)));
    endtask

    // drive on a falling edge, sample on the next falling edge
    task automatic do_req(input string req, input logic [1:0] k, input logic [17:0] a,
                          input bit hv);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; hv_override = hv;
        @(negedge clk);
        req_valid = 1'b0;
        check_both(req, k, a, hv);
    endtask

    task automatic do_probe(input string req, input bit im, input logic [17:0] a);
        @(negedge clk);
        id_mode = im; rd_addr = a;
        @(negedge clk);
        id_mode = 1'b0;
        check(req, "bottom status", 16'({h_b, s_b}), 16'(ref_status(im, a, 1'b0, mdl_lock)));
        check(req, "top status", 16'({h_t, s_t}), 16'(ref_status(im, a, 1'b1, mdl_lock)));
    endtask

    task automatic pulse_lock();
        @(negedge clk); lock_set = 1'b1;
        @(negedge clk); lock_set = 1'b0;
        mdl_lock = 1'b1;
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic pulse_por();
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
        mdl_lock = 1'b0;
    endtask

    function automatic logic [17:0] pick_addr(input int unsigned r);
        logic [17:0] edges [0:15];
        edges = '{18'h00000, 18'h03FFF, 18'h04000, 18'h05FFF, 18'h06000, 18'h07FFF,
                  18'h08000, 18'h1FFFF, 18'h20000, 18'h37FFF, 18'h38000, 18'h39FFF,
                  18'h3A000, 18'h3BFFF, 18'h3C000, 18'h3FFFF};
        if (r[3]) return edges[r[7:4]];
        return r[25:8];
    endfunction

    initial begin
        #(20.0 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [17:0] sect_pts [0:17];
        int unsigned seed;
        sect_pts = '{18'h00000, 18'h03FFF, 18'h04000, 18'h05FFF, 18'h06000, 18'h07FFF,
                     18'h08000, 18'h1FFFF, 18'h20000, 18'h3FFFF, 18'h3C000, 18'h3BFFF,
                     18'h3A000, 18'h39FFF, 18'h38000, 18'h37FFF, 18'h2ABCD, 18'h10000};
        seed = 32'd4242;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        rst = 1'b0; por = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11", "bottom outputs", 16'({g_b, r_b, n_b, m_b, h_b, s_b}), 16'h0);
        check("R11", "top outputs", 16'({g_t, r_t, n_t, m_t, h_t, s_t}), 16'h0);
        check("R8", "lock after por", 16'({l_b, l_t}), 16'h0);

        // R1 R2 R3 R4 sector decode over the edges of both layouts
        foreach (sect_pts[i]) do_req("R1_R2_R3_R4", 2'd1, sect_pts[i], 1'b0);

        do_req("R5", 2'd2, 18'h15555, 1'b0);
        do_req("R6", 2'd0, 18'h00010, 1'b0);
        do_req("R6", 2'd0, 18'h3C010, 1'b0);

        // R8 lock set
        pulse_lock();
        check("R8", "lock after strobe", 16'({l_b, l_t}), 16'h3);
        do_req("R6", 2'd0, 18'h00010, 1'b0);
        do_req("R6", 2'd0, 18'h3FFFF, 1'b0);
        do_req("R5", 2'd2, 18'h15555, 1'b0);
        // R7 override lifts protection, then drops
        do_req("R7", 2'd0, 18'h00010, 1'b1);
        do_req("R7", 2'd2, 18'h15555, 1'b1);
        do_req("R7", 2'd0, 18'h3C000, 1'b1);
        do_req("R7", 2'd0, 18'h03FFF, 1'b0);
        do_req("R7", 2'd2, 18'h15555, 1'b0);
        do_req("R4", 2'd1, 18'h00000, 1'b1);
        do_req("R4", 2'd1, 18'h3C000, 1'b1);

        // R8 ordinary reset keeps the lock
        pulse_rst();
        check("R8", "lock after rst", 16'({l_b, l_t}), 16'h3);
        check("R11", "outputs after rst", 16'({g_b, m_b, g_t, m_t}), 16'h0);

        // R9 lock probe
        do_probe("R9", 1'b1, 18'h00002);
        do_probe("R9", 1'b1, 18'h3C002);
        do_probe("R9", 1'b1, 18'h00003);
        do_probe("R9", 1'b0, 18'h00002);

        // R10 reserved kind and pulse behaviour
        do_req("R10", 2'd3, 18'h00010, 1'b0);
        do_req("R10", 2'd1, 18'h05000, 1'b0);
        @(negedge clk);
        check("R10", "idle after request", 16'({g_b, r_b, n_b, m_b, g_t, r_t, n_t, m_t}), 16'h0);

        pulse_por();
        check("R8", "lock after second por", 16'({l_b, l_t}), 16'h0);
        do_probe("R9", 1'b1, 18'h00002);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned r;
            r = $urandom();
            case (r[31:28])
                4'd0: pulse_lock();
                4'd1: pulse_rst();
                4'd2: if (r[27:25] == 3'd0) pulse_por(); else pulse_lock();
                4'd3: do_probe("R9", r[0], r[1] ? 18'h00002 : (r[2] ? 18'h3C002 : 18'(r[24:7])));
                default: do_req("R1_R5_R6_R7", 2'(r[1:0]), pick_addr($urandom()), r[2]);
            endcase
        end
        check("R8", "lock vs model", 16'({l_b, l_t}), mdl_lock ? 16'h3 : 16'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule